// File: doc/BRIEF.md
# USB Host Channel Interrupt Aggregator

This block gathers the per-channel transaction events that a full-speed USB host engine reports and turns them into interrupt state. Each channel has a sticky status word with nine event bits and a matching mask word. Every status bit is paired with one mask bit. The block then summarises the channels in two stages. First, one bit per channel is set when that channel has any unmasked pending event. Second, a single host-channel bit is set when any channel bit is set. That bit, gated by a global enable, drives one interrupt line.

The engine raises single-cycle strobes per channel. Several distinct bus faults are merged into one transaction-error bit. A halted bit records that the channel stopped for any reason. A transfer counts as complete only after both the memory side and the wire side report that they are finished. Software uses a word-addressed read/write port. Status words are cleared by writing ones. Mask words and the enable bit are plain read/write. The two summary words are read-only.

Top module: `usb_hc_irq_agg`

## Requirements
- R1: After reset, every status word, every mask word and the enable bit read 0, and `irq` is 0.
- R2: The status word of channel c is read at address c (c = 0..7). Its bit positions are: 0 transfer complete, 1 halted, 2 ACK, 3 NAK, 4 STALL, 5 transaction error, 6 babble, 7 frame overrun, 8 data-toggle error. A strobe sampled at a clock edge sets its bit at that edge.
- R3: A CRC, timeout, bit-stuff or false end-of-packet strobe sets bit 5. It also sets bit 1 (halted) at the same edge.
- R4: The halted bit sets on a disable-done strobe alone, on transfer completion, or on a transaction error.
- R5: Transfer complete (bit 0), together with halted, sets only once both the memory-side-done and wire-side-done strobes have been seen for the channel. The two strobes may arrive in either order or in the same cycle. After completion the pair is forgotten.
- R6: Status bits are sticky. Writing 1 to a status bit clears that bit. Writing 0 leaves the bit unchanged.
- R7: If a strobe and a clearing write hit the same bit in the same cycle, the bit ends set.
- R8: The mask word of channel c is at address 8+c, with the same bit positions as the status word. A mask bit of 1 enables its source. A source whose mask bit is 0 never contributes to any summary.
- R9: Address 16 is read-only. Its bit c is the OR, over all nine sources, of channel c's status bit ANDed with the matching mask bit. Writes to address 16 have no effect.
- R10: Address 17 bit 0 is read-only and is the OR of the address-16 bits. Address 18 bit 0 is the read/write enable. `irq` equals address-17 bit 0 AND the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_mem_done | input | 8 | Per channel: memory side of the transfer finished |
| ev_wire_done | input | 8 | Per channel: USB side of the transfer finished |
| ev_ack | input | 8 | Per channel: ACK handshake received |
| ev_nak | input | 8 | Per channel: NAK handshake received |
| ev_stall | input | 8 | Per channel: STALL handshake received |
| ev_crc | input | 8 | Per channel: CRC failure |
| ev_tmo | input | 8 | Per channel: response timeout |
| ev_stuff | input | 8 | Per channel: bit-stuff violation |
| ev_eop | input | 8 | Per channel: false end-of-packet |
| ev_babble | input | 8 | Per channel: babble detected |
| ev_ovr | input | 8 | Per channel: frame overrun |
| ev_tgl | input | 8 | Per channel: data-toggle mismatch |
| ev_dis | input | 8 | Per channel: stopped after a disable command |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives each fault strobe on its own. A design that failed to merge a fault, or that forgot to set halted along with it, would show the wrong status word. Completion is tested with the two side strobes in the same cycle and in both orders, split across vectors. A design that completed on either strobe alone would set bit 0 too early. A design that kept stale tracking would fire twice. Clearing writes are issued in the same cycle as a strobe to the same bit, which catches a design that lets the clear win. The bench also checks that writing zeros, or writing to bits that are not set, leaves status untouched. Masking is checked with a pending event whose mask bit is off while another mask bit is on, which exposes a design that ORs the mask word in as a whole. Writes to the summary address must not change it, and the enable must gate `irq` without hiding the global bit.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
  localparam int NSRC = 9;

  localparam int B_XFER  = 0;
  localparam int B_HALT  = 1;
  localparam int B_ACK   = 2;
  localparam int B_NAK   = 3;
  localparam int B_STALL = 4;
  localparam int B_TXERR = 5;
  localparam int B_BABL  = 6;
  localparam int B_OVR   = 7;
  localparam int B_TGL   = 8;

  typedef logic [NSRC-1:0] src_vec_t;

  // Sticky update: clear by ones written, then set by events (set wins).
  function automatic src_vec_t sticky_next(src_vec_t cur, src_vec_t set, src_vec_t clr);
    return (cur & ~clr) | set;
  endfunction

  // Pending = status bits whose source is enabled.
  function automatic src_vec_t pending(src_vec_t stat, src_vec_t en);
    return stat & en;
  endfunction
endpackage

// File: rtl/hc_event_decode.sv
module hc_event_decode
  import hc_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            ev_mem_done,
  input  logic [NCH-1:0]            ev_wire_done,
  input  logic [NCH-1:0]            ev_ack,
  input  logic [NCH-1:0]            ev_nak,
  input  logic [NCH-1:0]            ev_stall,
  input  logic [NCH-1:0]            ev_crc,
  input  logic [NCH-1:0]            ev_tmo,
  input  logic [NCH-1:0]            ev_stuff,
  input  logic [NCH-1:0]            ev_eop,
  input  logic [NCH-1:0]            ev_babble,
  input  logic [NCH-1:0]            ev_ovr,
  input  logic [NCH-1:0]            ev_tgl,
  input  logic [NCH-1:0]            ev_dis,
  output logic [NCH-1:0]            xfer_fire,
  output logic [NCH-1:0]            txn_err,
  output logic [NCH-1:0][NSRC-1:0]  set_vec
);
  logic [NCH-1:0] mem_seen_q, wire_seen_q;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      xfer_fire[c] = (mem_seen_q[c] | ev_mem_done[c]) & (wire_seen_q[c] | ev_wire_done[c]);
      txn_err[c]   = ev_crc[c] | ev_tmo[c] | ev_stuff[c] | ev_eop[c];
      set_vec[c]          = '0;
      set_vec[c][B_XFER]  = xfer_fire[c];
      set_vec[c][B_HALT]  = xfer_fire[c] | txn_err[c] | ev_dis[c];
      set_vec[c][B_ACK]   = ev_ack[c];
      set_vec[c][B_NAK]   = ev_nak[c];
      set_vec[c][B_STALL] = ev_stall[c];
      set_vec[c][B_TXERR] = txn_err[c];
      set_vec[c][B_BABL]  = ev_babble[c];
      set_vec[c][B_OVR]   = ev_ovr[c];
      set_vec[c][B_TGL]   = ev_tgl[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_seen_q  <= '0;
      wire_seen_q <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (xfer_fire[c]) begin
          mem_seen_q[c]  <= 1'b0;
          wire_seen_q[c] <= 1'b0;
        end else begin
          mem_seen_q[c]  <= mem_seen_q[c] | ev_mem_done[c];
          wire_seen_q[c] <= wire_seen_q[c] | ev_wire_done[c];
        end
      end
    end
  end
endmodule

// File: rtl/hc_status_bank.sv
module hc_status_bank
  import hc_irq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 5,
  parameter int DW  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0][NSRC-1:0]  set_vec,
  input  logic                      reg_wr,
  input  logic [AW-1:0]             reg_addr,
  input  logic [DW-1:0]             reg_wdata,
  output logic [NCH-1:0][NSRC-1:0]  clr_vec,
  output logic [NCH-1:0][NSRC-1:0]  status_q,
  output logic [NCH-1:0][NSRC-1:0]  mask_q
);
  logic [NCH-1:0] mask_we;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      clr_vec[c] = (reg_wr && reg_addr == AW'(c)) ? reg_wdata[NSRC-1:0] : '0;
      mask_we[c] = reg_wr && reg_addr == AW'(NCH + c);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        status_q[c] <= sticky_next(status_q[c], set_vec[c], clr_vec[c]);
        if (mask_we[c]) mask_q[c] <= reg_wdata[NSRC-1:0];
      end
    end
  end
endmodule

// File: rtl/hc_summary.sv
module hc_summary
  import hc_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0][NSRC-1:0]  status_q,
  input  logic [NCH-1:0][NSRC-1:0]  mask_q,
  output logic [NCH-1:0]            chan_sum,
  output logic                      glob_pend
);
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      chan_sum[c] = |pending(status_q[c], mask_q[c]);
    end
    glob_pend = |chan_sum;
  end
endmodule

// File: rtl/usb_hc_irq_agg.sv
module usb_hc_irq_agg
  import hc_irq_pkg::*;
#(
  parameter int  NCH = 8,
  parameter int  DW  = 32,
  localparam int AW  = $clog2(2 * NCH + 3)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev_mem_done,
  input  logic [NCH-1:0] ev_wire_done,
  input  logic [NCH-1:0] ev_ack,
  input  logic [NCH-1:0] ev_nak,
  input  logic [NCH-1:0] ev_stall,
  input  logic [NCH-1:0] ev_crc,
  input  logic [NCH-1:0] ev_tmo,
  input  logic [NCH-1:0] ev_stuff,
  input  logic [NCH-1:0] ev_eop,
  input  logic [NCH-1:0] ev_babble,
  input  logic [NCH-1:0] ev_ovr,
  input  logic [NCH-1:0] ev_tgl,
  input  logic [NCH-1:0] ev_dis,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq
);
  localparam int A_SUM = 2 * NCH;
  localparam int A_GLB = 2 * NCH + 1;
  localparam int A_EN  = 2 * NCH + 2;

  logic [NCH-1:0][NSRC-1:0] set_vec, clr_vec, status_q, mask_q;
  logic [NCH-1:0]           xfer_fire, txn_err, chan_sum;
  logic                     glob_pend, glob_en;

  hc_event_decode #(.NCH(NCH)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .ev_mem_done(ev_mem_done), .ev_wire_done(ev_wire_done),
    .ev_ack(ev_ack), .ev_nak(ev_nak), .ev_stall(ev_stall),
    .ev_crc(ev_crc), .ev_tmo(ev_tmo), .ev_stuff(ev_stuff), .ev_eop(ev_eop),
    .ev_babble(ev_babble), .ev_ovr(ev_ovr), .ev_tgl(ev_tgl), .ev_dis(ev_dis),
    .xfer_fire(xfer_fire), .txn_err(txn_err), .set_vec(set_vec)
  );

  hc_status_bank #(.NCH(NCH), .AW(AW), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .clr_vec(clr_vec), .status_q(status_q), .mask_q(mask_q)
  );

  hc_summary #(.NCH(NCH)) u_sum (
    .status_q(status_q), .mask_q(mask_q),
    .chan_sum(chan_sum), .glob_pend(glob_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                               glob_en <= 1'b0;
    else if (reg_wr && reg_addr == AW'(A_EN)) glob_en <= reg_wdata[0];
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == AW'(c))       reg_rdata[NSRC-1:0] = status_q[c];
      if (reg_addr == AW'(NCH + c)) reg_rdata[NSRC-1:0] = mask_q[c];
    end
    if (reg_addr == AW'(A_SUM)) reg_rdata[NCH-1:0] = chan_sum;
    if (reg_addr == AW'(A_GLB)) reg_rdata[0] = glob_pend;
    if (reg_addr == AW'(A_EN))  reg_rdata[0] = glob_en;
  end

  assign irq = glob_pend & glob_en;
endmodule

// File: rtl/hc_irq_agg_chk.sv
module hc_irq_agg_chk
  import hc_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            ev_crc,
  input logic [NCH-1:0]            ev_tmo,
  input logic [NCH-1:0]            ev_stuff,
  input logic [NCH-1:0]            ev_eop,
  input logic [NCH-1:0][NSRC-1:0]  set_vec,
  input logic [NCH-1:0][NSRC-1:0]  clr_vec,
  input logic [NCH-1:0][NSRC-1:0]  status_q,
  input logic [NCH-1:0][NSRC-1:0]  mask_q,
  input logic [NCH-1:0]            chan_sum,
  input logic                      glob_en,
  input logic                      irq
);
  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~$past(clr_vec)) & ~status_q) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_vec) & ~status_q) == '0));

  // R8
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (chan_sum == '0));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (glob_en && (|chan_sum)));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R3
    txn_err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_crc[c] | ev_tmo[c] | ev_stuff[c] | ev_eop[c]) |=>
        (status_q[c][B_TXERR] && status_q[c][B_HALT]));
  end
endmodule

bind usb_hc_irq_agg hc_irq_agg_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_crc(ev_crc), .ev_tmo(ev_tmo), .ev_stuff(ev_stuff), .ev_eop(ev_eop),
  .set_vec(set_vec), .clr_vec(clr_vec), .status_q(status_q), .mask_q(mask_q),
  .chan_sum(chan_sum), .glob_en(glob_en), .irq(irq)
);

// File: tb/tb_usb_hc_irq_agg.sv
module tb_usb_hc_irq_agg;
  localparam int NCH = 8;
  localparam int AW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ev_mem_done = '0, ev_wire_done = '0, ev_ack = '0, ev_nak = '0,
                  ev_stall = '0, ev_crc = '0, ev_tmo = '0, ev_stuff = '0, ev_eop = '0,
                  ev_babble = '0, ev_ovr = '0, ev_tgl = '0, ev_dis = '0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  usb_hc_irq_agg dut (
    .clk(clk), .rst_n(rst_n),
    .ev_mem_done(ev_mem_done), .ev_wire_done(ev_wire_done),
    .ev_ack(ev_ack), .ev_nak(ev_nak), .ev_stall(ev_stall),
    .ev_crc(ev_crc), .ev_tmo(ev_tmo), .ev_stuff(ev_stuff), .ev_eop(ev_eop),
    .ev_babble(ev_babble), .ev_ovr(ev_ovr), .ev_tgl(ev_tgl), .ev_dis(ev_dis),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // Event pattern bits: 0 mem_done, 1 wire_done, 2 ack, 3 nak, 4 stall, 5 crc,
  // 6 tmo, 7 stuff, 8 eop, 9 babble, 10 ovr, 11 tgl, 12 dis.
  // Vector: {channel[2:0], events[12:0], expected status[8:0]}
  localparam int NV = 15;
  localparam logic [24:0] VEC [NV] = '{
    {3'd0, 13'h0004, 9'h004},  // R2 ACK
    {3'd1, 13'h0008, 9'h008},  // R2 NAK
    {3'd2, 13'h0010, 9'h010},  // R2 STALL
    {3'd3, 13'h0020, 9'h022},  // R3 CRC
    {3'd4, 13'h0040, 9'h022},  // R3 timeout
    {3'd5, 13'h0080, 9'h022},  // R3 bit stuff
    {3'd6, 13'h0100, 9'h022},  // R3 false EOP
    {3'd7, 13'h0200, 9'h040},  // R2 babble
    {3'd0, 13'h0400, 9'h080},  // R2 overrun
    {3'd1, 13'h0800, 9'h100},  // R2 toggle
    {3'd2, 13'h1000, 9'h002},  // R4 disable-done
    {3'd3, 13'h0003, 9'h003},  // R5 both sides same cycle
    {3'd4, 13'h0001, 9'h000},  // R5 memory side only
    {3'd4, 13'h0002, 9'h003},  // R5 wire side completes it
    {3'd5, 13'h000C, 9'h00C}   // R2 ACK+NAK together
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ev(input int ch, input logic [12:0] e);
    ev_mem_done[ch] = e[0];  ev_wire_done[ch] = e[1]; ev_ack[ch] = e[2];
    ev_nak[ch] = e[3];       ev_stall[ch] = e[4];     ev_crc[ch] = e[5];
    ev_tmo[ch] = e[6];       ev_stuff[ch] = e[7];     ev_eop[ch] = e[8];
    ev_babble[ch] = e[9];    ev_ovr[ch] = e[10];      ev_tgl[ch] = e[11];
    ev_dis[ch] = e[12];
  endtask

  task automatic idle_all();
    ev_mem_done = '0; ev_wire_done = '0; ev_ack = '0; ev_nak = '0; ev_stall = '0;
    ev_crc = '0; ev_tmo = '0; ev_stuff = '0; ev_eop = '0; ev_babble = '0;
    ev_ovr = '0; ev_tgl = '0; ev_dis = '0; reg_wr = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int ch, input logic [12:0] e);
    @(negedge clk);
    set_ev(ch, e);
    @(negedge clk);
    idle_all();
  endtask

  task automatic pulse_clear(input int ch, input logic [12:0] e, input logic [31:0] c);
    @(negedge clk);
    set_ev(ch, e);
    reg_wr = 1'b1; reg_addr = AW'(ch); reg_wdata = c;
    @(negedge clk);
    idle_all();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, d);  check("R1 status ch0", d, 32'h0);
    rd(7, d);  check("R1 status ch7", d, 32'h0);
    rd(8, d);  check("R1 mask ch0", d, 32'h0);
    rd(16, d); check("R1 channel summary", d, 32'h0);
    rd(18, d); check("R1 enable", d, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      int ch;
      ch = int'(VEC[i][24:22]);
      wr(ch, 32'h1FF);
      pulse(ch, VEC[i][21:9]);
      rd(ch, d);
      check($sformatf("R2/R3/R4/R5 vector %0d", i), d, {23'h0, VEC[i][8:0]});
    end

    // R5 reverse order: wire side first, then memory side
    wr(6, 32'h1FF);
    pulse(6, 13'h0002);
    rd(6, d); check("R5 wire side alone", d, 32'h0);
    pulse(6, 13'h0001);
    rd(6, d); check("R5 memory side completes", d, 32'h003);

    for (int c = 0; c < NCH; c++) wr(c, 32'h1FF);

    // R8 masking
    pulse(2, 13'h0004);
    rd(16, d); check("R8 all masked", d, 32'h0);
    wr(10, 32'h008);
    rd(16, d); check("R8 other source enabled", d, 32'h0);
    wr(10, 32'h004);
    rd(16, d); check("R9 channel 2 summary", d, 32'h04);
    rd(17, d); check("R10 global bit", d, 32'h1);
    check("R10 irq gated off", {31'h0, irq}, 32'h0);
    wr(18, 32'h1);
    check("R10 irq enabled", {31'h0, irq}, 32'h1);
    wr(16, 32'hFF);
    rd(16, d); check("R9 summary read-only", d, 32'h04);

    // R6 write-one-to-clear
    wr(2, 32'h000);
    rd(2, d); check("R6 write zero keeps", d, 32'h004);
    wr(2, 32'h008);
    rd(2, d); check("R6 other bit write keeps", d, 32'h004);
    wr(2, 32'h004);
    rd(2, d); check("R6 write one clears", d, 32'h000);
    rd(17, d); check("R10 global drops", d, 32'h0);
    check("R10 irq drops", {31'h0, irq}, 32'h0);

    // R7 set beats clear
    pulse_clear(3, 13'h0004, 32'h004);
    rd(3, d); check("R7 set wins same bit", d, 32'h004);
    pulse(3, 13'h0008);
    pulse_clear(3, 13'h0004, 32'h00C);
    rd(3, d); check("R7 set wins, other bit cleared", d, 32'h004);

    finish_run();
  end
endmodule